// File: doc/BRIEF.md
# Static Memory Strobe Timer

This block drives the three active-low strobes of an asynchronous static memory: chip enable, output enable and write enable. Each access is timed by counting base clocks, where one base clock is two system clocks. The lengths come from six programmable timing fields: read cycle, write cycle, enable-to-output delay, write pulse, page cycle and bus turnaround. Software first loads the fields into a staging register. The fields reach the active timing set only when an update command is issued. The update is checked before it is applied. A prohibited code, or a set whose pulse does not fit inside its cycle, is refused and leaves the active set as it was.

A requester pulses a start input together with a read/write select while the block is idle. The block then runs one memory cycle and pulses done in the cycle's last clock. After that it holds a turnaround gap before it accepts the next request. A mode input selects separate-bus or multiplexed-bus operation. In multiplexed mode the write pulse is one base clock longer, the write margin is stricter, and the page-cycle setting is not used.

Top module: `sram_strobe_timer`

## Requirements
- R1: After reset ceN, oeN and weN are 1, done, busy and cfgErr are 0. The active set holds the slowest legal codes: 15 for both cycle times and 7 for every 3-bit field.
- R2: A read that starts on the clock edge where reqStart=1 and busy=0 holds ceN at 0 for 2×read-cycle system clocks, beginning with the clock after that edge. oeN goes to 0 after 2×enable-delay of those clocks and stays at 0 until ceN returns to 1. weN stays at 1.
- R3: A write in separate-bus mode holds ceN at 0 for 2×write-cycle clocks. weN goes to 0 from the third clock of the cycle for 2×write-pulse clocks. oeN stays at 1.
- R4: In multiplexed-bus mode (muxMode=1) the write pulse lasts 2×(write-pulse+1) clocks.
- R5: done is 1 for exactly one clock, and that clock is the last one in which ceN is 0.
- R6: busy stays 1 for 2×turnaround clocks after ceN returns to 1. A reqStart pulse while busy=1 is ignored.
- R7: cfgData fields are packed as read cycle [19:16], write cycle [15:12], enable delay [11:9], write pulse [8:6], page cycle [5:3] and turnaround [2:0]. cfgWrite loads them into the staging register only. Cycles keep the old timing until updCmd is given.
- R8: An updCmd that arrives while busy=1 is held. The running cycle keeps its timing, and the new set applies from the next cycle.
- R9: An update is refused, with cfgErr set to 1 and the active set unchanged, if any of these holds: the read cycle is below 2, the write cycle is below 3, or any 3-bit field is 0.
- R10: An update is also refused if enable delay + 1 is greater than the read cycle, or if write pulse + margin is greater than the write cycle. The margin is 2 in separate mode and 3 in multiplexed mode, taken from muxMode when the update is applied.
- R11: pageTime shows the active page-cycle code in separate mode and 0 in multiplexed mode.
- R12: An accepted update clears cfgErr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgData | input | 20 | Timing fields to be staged |
| cfgWrite | input | 1 | Load cfgData into the staging register |
| updCmd | input | 1 | Copy the staged set into the active set |
| muxMode | input | 1 | 1 = multiplexed bus, 0 = separate bus |
| reqStart | input | 1 | Start pulse for one memory cycle |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| weN | output | 1 | Write enable, active low |
| done | output | 1 | One-clock pulse at the end of the cycle |
| busy | output | 1 | Cycle or turnaround in progress |
| cfgErr | output | 1 | The last update was refused |
| pageTime | output | 3 | Page-cycle code in effect |

## Verification
The bench runs reads and writes in both bus modes. The field values range from the smallest legal codes to the slowest set. Comparing the same write pulse in both modes shows whether the one-clock stretch is applied. Comparing short and long enable delays shows whether the output-enable offset is counted in base clocks or in system clocks. Update commands are given in three situations: staged with no update, issued in the middle of a cycle, and carrying a set that breaks a code rule or the mode-dependent margin. These cases tell apart staging, deferral and rejection, because each one leaves a different cycle length on the next access.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int LONG_W  = 4;
  localparam int SHORT_W = 3;

  typedef struct packed {
    logic [LONG_W-1:0]  rdCyc;
    logic [LONG_W-1:0]  wrCyc;
    logic [SHORT_W-1:0] oeDly;
    logic [SHORT_W-1:0] wePls;
    logic [SHORT_W-1:0] pgCyc;
    logic [SHORT_W-1:0] turnCyc;
  } timing_t;

  localparam int CFG_W = $bits(timing_t);

  localparam timing_t SLOW_SET = '{rdCyc: '1, wrCyc: '1, oeDly: '1,
                                   wePls: '1, pgCyc: '1, turnCyc: '1};

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadStage;
    logic applyCfg;
    logic startCyc;
    logic clrCnt;
    logic inActive;
    logic inTurn;
  } ctlStrobe_t;
endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl import sst_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqStart,
  input  logic       cfgWrite,
  input  logic       updCmd,
  input  logic       cycEnd,
  input  logic       turnEnd,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_ACT, S_TURN} state_t;
  state_t state, nextState;
  logic   updPending;

  always_comb begin
    ctl           = '0;
    ctl.loadStage = cfgWrite;
    ctl.inActive  = (state == S_ACT);
    ctl.inTurn    = (state == S_TURN);
    ctl.applyCfg  = (state == S_IDLE) && (updCmd || updPending);
    ctl.startCyc  = (state == S_IDLE) && reqStart;
    ctl.clrCnt    = ctl.startCyc || (ctl.inActive && cycEnd) || (ctl.inTurn && turnEnd);
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (reqStart) nextState = S_ACT;
      S_ACT:   if (cycEnd)   nextState = S_TURN;
      S_TURN:  if (turnEnd)  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      updPending <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.applyCfg)  updPending <= 1'b0;
      else if (updCmd)   updPending <= 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = ctl.inActive && cycEnd;
endmodule

// File: rtl/sst_datapath.sv
module sst_datapath import sst_pkg::*; #(
  parameter int MIN_RD        = 2,
  parameter int MIN_WR        = 3,
  parameter int RD_MARGIN     = 1,
  parameter int WR_MARGIN_SEP = 2,
  parameter int WR_MARGIN_MUX = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  timing_t            cfgIn,
  input  logic               reqWrite,
  input  logic               muxMode,
  output logic               cycEnd,
  output logic               turnEnd,
  output logic               ceN,
  output logic               oeN,
  output logic               weN,
  output logic               cfgErr,
  output logic [SHORT_W-1:0] pageTime,
  output timing_t            activeCfg
);
  localparam int CNT_W = LONG_W + 2;

  timing_t            stageCfg;
  logic [CNT_W-1:0]   cnt;
  logic               cycWr, cycMux;
  int                 wrMargin;
  logic               codesOk, orderOk;
  logic [LONG_W-1:0]  cycLen;
  logic [SHORT_W:0]   weEff;
  logic [CNT_W-1:0]   lastCnt, turnLast, oeStart, weStop;

  // legality of the staged set, judged in the mode in force at apply time
  assign wrMargin = muxMode ? WR_MARGIN_MUX : WR_MARGIN_SEP;
  assign codesOk  = (int'(stageCfg.rdCyc) >= MIN_RD) && (int'(stageCfg.wrCyc) >= MIN_WR) &&
                    (stageCfg.oeDly != '0) && (stageCfg.wePls != '0) &&
                    (stageCfg.pgCyc != '0) && (stageCfg.turnCyc != '0);
  assign orderOk  = (int'(stageCfg.oeDly) + RD_MARGIN <= int'(stageCfg.rdCyc)) &&
                    (int'(stageCfg.wePls) + wrMargin  <= int'(stageCfg.wrCyc));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCfg  <= SLOW_SET;
      activeCfg <= SLOW_SET;
      cfgErr    <= 1'b0;
      cnt       <= '0;
      cycWr     <= 1'b0;
      cycMux    <= 1'b0;
    end else begin
      if (ctl.loadStage) stageCfg <= cfgIn;
      if (ctl.applyCfg) begin
        if (codesOk && orderOk) begin
          activeCfg <= stageCfg;
          cfgErr    <= 1'b0;
        end else begin
          cfgErr    <= 1'b1;
        end
      end
      if (ctl.startCyc) begin
        cycWr  <= reqWrite;
        cycMux <= muxMode;
      end
      if (ctl.clrCnt)                       cnt <= '0;
      else if (ctl.inActive || ctl.inTurn)  cnt <= cnt + 1'b1;
    end
  end

  // every length is counted in system clocks, two per base clock
  assign cycLen   = cycWr ? activeCfg.wrCyc : activeCfg.rdCyc;
  assign lastCnt  = CNT_W'({cycLen, 1'b0}) - CNT_W'(1);
  assign turnLast = CNT_W'({activeCfg.turnCyc, 1'b0}) - CNT_W'(1);
  assign oeStart  = CNT_W'({activeCfg.oeDly, 1'b0});
  assign weEff    = {1'b0, activeCfg.wePls} + {{SHORT_W{1'b0}}, cycMux};
  assign weStop   = CNT_W'({weEff, 1'b0}) + CNT_W'(2);

  assign cycEnd   = (cnt == lastCnt);
  assign turnEnd  = (cnt == turnLast);

  assign ceN = !ctl.inActive;
  assign oeN = !(ctl.inActive && !cycWr && (cnt >= oeStart));
  assign weN = !(ctl.inActive && cycWr && (cnt >= CNT_W'(2)) && (cnt < weStop));

  assign pageTime = muxMode ? '0 : activeCfg.pgCyc;
endmodule

// File: rtl/sram_strobe_timer.sv
module sram_strobe_timer import sst_pkg::*; #(
  parameter int MIN_RD        = 2,
  parameter int MIN_WR        = 3,
  parameter int RD_MARGIN     = 1,
  parameter int WR_MARGIN_SEP = 2,
  parameter int WR_MARGIN_MUX = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               cfgWrite,
  input  logic               updCmd,
  input  logic               muxMode,
  input  logic               reqStart,
  input  logic               reqWrite,
  output logic               ceN,
  output logic               oeN,
  output logic               weN,
  output logic               done,
  output logic               busy,
  output logic               cfgErr,
  output logic [SHORT_W-1:0] pageTime
);
  ctlStrobe_t ctl;
  logic       cycEnd, turnEnd;
  timing_t    activeCfg;

  sst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .cfgWrite(cfgWrite),
    .updCmd(updCmd), .cycEnd(cycEnd), .turnEnd(turnEnd),
    .ctl(ctl), .busy(busy), .done(done)
  );

  sst_datapath #(
    .MIN_RD(MIN_RD), .MIN_WR(MIN_WR), .RD_MARGIN(RD_MARGIN),
    .WR_MARGIN_SEP(WR_MARGIN_SEP), .WR_MARGIN_MUX(WR_MARGIN_MUX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgIn(timing_t'(cfgData)),
    .reqWrite(reqWrite), .muxMode(muxMode), .cycEnd(cycEnd), .turnEnd(turnEnd),
    .ceN(ceN), .oeN(oeN), .weN(weN), .cfgErr(cfgErr), .pageTime(pageTime),
    .activeCfg(activeCfg)
  );
endmodule

// File: rtl/sst_checker.sv
module sst_checker import sst_pkg::*; (
  input logic    clk,
  input logic    rstN,
  input logic    ceN,
  input logic    oeN,
  input logic    weN,
  input logic    done,
  input logic    busy,
  input logic    cfgErr,
  input timing_t activeCfg
);
  // R1: strobes idle high while reset is held
  always @(posedge clk) begin
    if (!rstN) a_r1_reset_idle: assert (ceN && oeN && weN && !done && !busy);
  end

  a_r2_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));

  a_r5_done_ends_ce: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ceN);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceN) |-> !$past(busy));

  a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(activeCfg));

  a_r9_reject_keeps_set: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> $stable(activeCfg));
endmodule

bind sram_strobe_timer sst_checker u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .done(done),
  .busy(busy), .cfgErr(cfgErr), .activeCfg(activeCfg)
);

// File: tb/sram_strobe_timer_tb.sv
module sram_strobe_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] cfgData = '0;
  logic        cfgWrite = 1'b0, updCmd = 1'b0, muxMode = 1'b0;
  logic        reqStart = 1'b0, reqWrite = 1'b0;
  logic        ceN, oeN, weN, done, busy, cfgErr;
  logic [2:0]  pageTime;

  int checks = 0;
  int fails  = 0;
  logic [19:0] midCfg = '0;

  always #4 clk = ~clk;

  sram_strobe_timer u_dut (
    .clk(clk), .rstN(rstN), .cfgData(cfgData), .cfgWrite(cfgWrite), .updCmd(updCmd),
    .muxMode(muxMode), .reqStart(reqStart), .reqWrite(reqWrite), .ceN(ceN), .oeN(oeN),
    .weN(weN), .done(done), .busy(busy), .cfgErr(cfgErr), .pageTime(pageTime)
  );

  typedef struct packed {
    logic       mux;
    logic       wr;
    logic [19:0] cfg;
    logic [7:0] ce, oe, we, bsy;
    logic [2:0] pg;
  } vec_t;

  // fields: {read, write, enable delay, write pulse, page, turnaround}
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, {4'd5, 4'd7, 3'd2, 3'd3, 3'd1, 3'd1}, 8'd10, 8'd6,  8'd0, 8'd12, 3'd1},
    '{1'b0, 1'b1, {4'd5, 4'd6, 3'd2, 3'd3, 3'd2, 3'd2}, 8'd12, 8'd0,  8'd6, 8'd16, 3'd2},
    '{1'b1, 1'b1, {4'd5, 4'd7, 3'd2, 3'd3, 3'd1, 3'd1}, 8'd14, 8'd0,  8'd8, 8'd16, 3'd0},
    '{1'b1, 1'b0, {4'd2, 4'd7, 3'd1, 3'd3, 3'd1, 3'd3}, 8'd4,  8'd2,  8'd0, 8'd10, 3'd0},
    '{1'b0, 1'b0, {4'd15,4'd15,3'd7, 3'd7, 3'd7, 3'd7}, 8'd30, 8'd16, 8'd0, 8'd44, 3'd7},
    '{1'b0, 1'b1, {4'd2, 4'd3, 3'd1, 3'd1, 3'd1, 3'd1}, 8'd6,  8'd0,  8'd2, 8'd8,  3'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stageApply(input logic [19:0] c);
    @(negedge clk); cfgData = c; cfgWrite = 1'b1;
    @(negedge clk); cfgWrite = 1'b0; updCmd = 1'b1;
    @(negedge clk); updCmd = 1'b0;
  endtask

  int ceC, oeC, weC, doneC, busyC, doneIdx, ceLast;

  // midAct: 0 none, 1 extra reqStart mid-cycle, 2 stage+update mid-cycle
  task automatic runCycle(input logic wr, input int midAct);
    int n;
    ceC = 0; oeC = 0; weC = 0; doneC = 0; busyC = 0; doneIdx = -1; ceLast = -2;
    @(negedge clk); reqWrite = wr; reqStart = 1'b1;
    @(negedge clk); reqStart = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      busyC++;
      if (!ceN) begin ceC++; ceLast = n; end
      if (!oeN) oeC++;
      if (!weN) weC++;
      if (done) begin doneC++; doneIdx = n; end
      if (n == 3 && midAct == 1) reqStart = 1'b1;
      if (n == 3 && midAct == 2) begin cfgData = midCfg; cfgWrite = 1'b1; updCmd = 1'b1; end
      if (n == 4) begin reqStart = 1'b0; cfgWrite = 1'b0; updCmd = 1'b0; end
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ceN", ceN, 1); chk("R1 oeN", oeN, 1); chk("R1 weN", weN, 1);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 cfgErr", cfgErr, 0);
    chk("R1 pageTime", pageTime, 7);
    runCycle(1'b0, 0);
    chk("R1 slow read ce", ceC, 30); chk("R1 slow read oe", oeC, 16);
    chk("R1 slow read busy", busyC, 44);

    // table-driven main function: R2 R3 R4 R5 R6 R11
    foreach (VECS[i]) begin
      muxMode = VECS[i].mux;
      stageApply(VECS[i].cfg);
      chk("R12 accepted", cfgErr, 0);
      #1 chk("R11 pageTime", pageTime, VECS[i].pg);
      runCycle(VECS[i].wr, 0);
      chk("R2 R3 ce length", ceC, VECS[i].ce);
      chk("R2 oe length", oeC, VECS[i].oe);
      chk("R3 R4 we length", weC, VECS[i].we);
      chk("R6 busy length", busyC, VECS[i].bsy);
      chk("R5 done count", doneC, 1);
      chk("R5 done at last ce", doneIdx, ceLast);
    end

    // R7: staging alone changes nothing (active rc=2 from last vector)
    muxMode = 1'b0;
    @(negedge clk); cfgData = {4'd4, 4'd6, 3'd1, 3'd2, 3'd3, 3'd1}; cfgWrite = 1'b1;
    @(negedge clk); cfgWrite = 1'b0;
    runCycle(1'b0, 0);
    chk("R7 staged not active", ceC, 4);
    @(negedge clk); updCmd = 1'b1;
    @(negedge clk); updCmd = 1'b0;
    runCycle(1'b0, 0);
    chk("R7 after update ce", ceC, 8); chk("R7 after update oe", oeC, 6);

    // R8: update during a cycle is deferred
    midCfg = {4'd6, 4'd6, 3'd3, 3'd2, 3'd3, 3'd2};
    runCycle(1'b0, 2);
    chk("R8 running cycle kept", ceC, 8);
    chk("R8 running busy kept", busyC, 10);
    runCycle(1'b0, 0);
    chk("R8 next cycle ce", ceC, 12); chk("R8 next cycle oe", oeC, 6);
    chk("R8 next cycle busy", busyC, 16);

    // R6: start pulse while busy ignored
    runCycle(1'b0, 1);
    chk("R6 ce with extra start", ceC, 12);
    chk("R6 busy with extra start", busyC, 16);
    chk("R6 idle after cycle", ceN, 1);
    @(negedge clk);
    chk("R6 stays idle", ceN, 1);
    chk("R6 not busy", busy, 0);

    // R9: prohibited codes
    stageApply({4'd1, 4'd6, 3'd1, 3'd2, 3'd3, 3'd1});
    chk("R9 read code 1 error", cfgErr, 1);
    runCycle(1'b0, 0);
    chk("R9 set kept", ceC, 12);
    stageApply({4'd6, 4'd6, 3'd0, 3'd2, 3'd3, 3'd1});
    chk("R9 zero delay error", cfgErr, 1);
    stageApply({4'd6, 4'd2, 3'd1, 3'd1, 3'd3, 3'd1});
    chk("R9 write code 2 error", cfgErr, 1);
    runCycle(1'b0, 0);
    chk("R9 set still kept", ceC, 12);

    // R12: a good update clears the error
    stageApply({4'd3, 4'd6, 3'd1, 3'd2, 3'd4, 3'd1});
    chk("R12 error cleared", cfgErr, 0);
    runCycle(1'b0, 0);
    chk("R12 new read ce", ceC, 6);

    // R10: mode-dependent write margin and read margin
    muxMode = 1'b1;
    stageApply({4'd3, 4'd5, 3'd1, 3'd3, 3'd4, 3'd1});
    chk("R10 mux margin reject", cfgErr, 1);
    runCycle(1'b1, 0);
    chk("R10 R4 mux write we", weC, 6);
    chk("R10 mux write ce", ceC, 12);
    #1 chk("R11 mux pageTime", pageTime, 0);
    muxMode = 1'b0;
    #1 chk("R11 sep pageTime", pageTime, 4);
    stageApply({4'd3, 4'd5, 3'd1, 3'd3, 3'd4, 3'd1});
    chk("R10 sep margin accept", cfgErr, 0);
    runCycle(1'b1, 0);
    chk("R10 sep write ce", ceC, 10); chk("R10 sep write we", weC, 6);
    stageApply({4'd3, 4'd5, 3'd3, 3'd3, 3'd4, 3'd1});
    chk("R10 read margin reject", cfgErr, 1);
    runCycle(1'b1, 0);
    chk("R10 set kept after reject", ceC, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule